// File: doc/BRIEF.md
# Timer Burst Register Window

This block lets a DMA engine read or write a run of consecutive 16-bit timer registers through one fixed buffer address. Software or the DMA setup code first writes a configuration register. That register holds the word index of the first register in the run and a length code, which is the number of registers minus one. Every access to the buffer address after that is redirected to the next register of the run.

After the last register of the run is reached, the block pulses `burst_done` and rewinds its internal index to the start of the run, so the next burst can begin at once. The registers behind the window also answer directly at their own word offsets. Writing the configuration register again abandons a burst that has not finished. The data lane is 16 bits wide, so a half-word bus access and a word bus access behave in the same way.

Top module: `tmr_burst_win`

## Requirements
- R1: After reset, the configuration register (byte offset 0x48) reads 0x0000, every bank register reads 0x0000, and `burst_done` is low.
- R2: In the configuration register, the start index sits in bits 4:0 and the length code sits in bits 12:8. Bits 15:13 and 7:5 always read as zero, whatever was written to them.
- R3: A length code written above 17 is stored and read back as 17, so a burst covers at most 18 registers.
- R4: With start S and length code C, the k-th buffer access (byte offset 0x4C), counting from k = 0 to C, reads or writes the bank register at word index S+k.
- R5: `burst_done` is high for exactly the one cycle after the clock edge that completes access number C. The access after that reaches index S again.
- R6: A buffer access whose target index is 18 or more reads 0x0000 and changes no register.
- R7: A write to the configuration register abandons any burst in progress. The next buffer access reaches the newly written start index.
- R8: Bank register i (0 to 17) is read and written directly at byte offset 4*i. Direct reads of byte offsets 0x48 and 0x4C never return bank contents: 0x48 returns the configuration register and 0x4C returns the current target of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | An access is made in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current access (combinational) |
| burst_done | output | 1 | One-cycle pulse after the last access of a burst |

## Verification
The assertions check on every cycle that the stored length code never goes above 17 and that the beat count never passes it. They also check that the index steps by one on each access within a burst, that a configuration write reloads the index, that the done pulse always leaves the index back at the start, and that an out-of-range target reads zero. Only the bench scenarios can show the data itself. These cover writes landing in the right register through the window, reads returning what was stored, dropped out-of-range writes leaving every other register untouched, reserved bits reading zero, and an abandoned burst restarting at the new start.

// File: rtl/tbw_pkg.sv
// Shared constants for the timer burst window: bus offsets and field layout.
// Assumes byte addressing with word-aligned registers.
package tbw_pkg;
    localparam int unsigned CFG_OFS   = 32'h48;  // configuration register
    localparam int unsigned BUF_OFS   = 32'h4C;  // transfer buffer register
    localparam int unsigned START_LSB = 0;       // start index field
    localparam int unsigned CNT_LSB   = 8;       // length code field
    localparam int unsigned FLD_W     = 5;       // width of both fields
endpackage

// File: rtl/tbw_cfg.sv
// Configuration register: holds the start index and the length code.
// Length codes above CNT_MAX are saturated to CNT_MAX. Reserved bits read
// as zero. Assumes DW >= CNT_LSB + FLD_W.
module tbw_cfg
    import tbw_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CNT_MAX = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [FLD_W-1:0] start_q,
    output logic [FLD_W-1:0] cnt_q,
    output logic [DW-1:0]    rd_word
);
    localparam logic [FLD_W-1:0] CNT_CAP = FLD_W'(CNT_MAX);

    logic [FLD_W-1:0] cnt_in;
    logic [FLD_W-1:0] cnt_sat;
    logic             unused_bits;

    assign cnt_in  = wdata[CNT_LSB +: FLD_W];
    assign unused_bits = ^wdata;

    // Clamp the incoming length code to the legal range.
    always_comb begin
        cnt_sat = (cnt_in > CNT_CAP) ? CNT_CAP : cnt_in;
    end

    // Capture the two fields on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (wr_en) begin
            start_q <= wdata[START_LSB +: FLD_W];
            cnt_q   <= cnt_sat;
        end
    end

    // Assemble the read image with reserved bits forced low.
    always_comb begin
        rd_word = '0;
        rd_word[START_LSB +: FLD_W] = start_q;
        rd_word[CNT_LSB +: FLD_W]   = cnt_q;
    end

    // R3
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_CAP)
        else $error("length code above cap");
endmodule

// File: rtl/tbw_seq.sv
// Burst sequencer: tracks the current target index and the beat number
// within a burst. It rewinds to the start index after the last beat and
// pulses done one cycle later. A configuration write reloads both counters.
// Assumes cfg_wr and buf_acc are never high together.
module tbw_seq
    import tbw_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [FLD_W-1:0] new_start,
    input  logic [FLD_W-1:0] start_q,
    input  logic [FLD_W-1:0] cnt_q,
    input  logic             buf_acc,
    output logic [IW-1:0]    idx_q,
    output logic             done_q
);
    logic [FLD_W-1:0] beat_q;
    logic             last_beat;

    assign last_beat = (beat_q == cnt_q);

    // Advance, rewind or reload the index and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            beat_q <= '0;
        end else if (cfg_wr) begin
            idx_q  <= IW'(new_start);
            beat_q <= '0;
        end else if (buf_acc) begin
            if (last_beat) begin
                idx_q  <= IW'(start_q);
                beat_q <= '0;
            end else begin
                idx_q  <= idx_q + 1'b1;
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= buf_acc && !cfg_wr && last_beat;
    end

    // R3
    beat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_q <= cnt_q)
        else $error("beat past length code");

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_acc && !cfg_wr && !last_beat) |=> (idx_q == $past(idx_q) + 1'b1))
        else $error("index did not step");

    // R5
    done_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (idx_q == IW'(start_q) && beat_q == '0))
        else $error("done without rewind");

    // R7
    cfg_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (idx_q == IW'($past(new_start)) && beat_q == '0))
        else $error("config write did not reload");
endmodule

// File: rtl/tbw_bank.sv
// Bank of NREG registers of DW bits each, with one read port and one write
// port indexed by word. Indices at or above NREG read zero and drop writes.
module tbw_bank #(
    parameter int DW   = 16,
    parameter int NREG = 18,
    parameter int IW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam logic [IW-1:0] LIMIT = IW'(NREG);

    logic [DW-1:0] regs [NREG];

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            // Each register loads when it is the addressed target.
            always_ff @(posedge clk) begin
                if (!rst_n)                          regs[gi] <= '0;
                else if (we && idx == IW'(gi))       regs[gi] <= wdata;
            end
        end
    endgenerate

    // Select the addressed register, or zero when out of range.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (idx == IW'(i)) rdata = regs[i];
    end

    // R6
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx >= LIMIT) |-> (rdata == '0))
        else $error("out-of-range read not zero");
endmodule

// File: rtl/tmr_burst_win.sv
// Top of the timer burst window. It decodes the bus offset into a config
// access, a buffer access (redirected through the sequencer) or a direct
// bank access. Read data is combinational. Assumes word-aligned offsets.
module tmr_burst_win
    import tbw_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 8,
    parameter int NREG    = 18,
    parameter int CNT_MAX = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          burst_done
);
    localparam int IW = $clog2((1 << FLD_W) + CNT_MAX + 1);
    localparam logic [AW-1:0] CFG_A = AW'(CFG_OFS);
    localparam logic [AW-1:0] BUF_A = AW'(BUF_OFS);
    localparam logic [AW-3:0] NREG_W = (AW-2)'(NREG);

    logic [AW-3:0]    word;
    logic             is_cfg, is_buf, is_dir;
    logic             cfg_wr, buf_acc, bank_we;
    logic [FLD_W-1:0] start_q, cnt_q;
    logic [DW-1:0]    cfg_word, bank_rd;
    logic [IW-1:0]    win_idx, bank_idx;
    logic             unused_lsb;

    assign word       = bus_addr[AW-1:2];
    assign unused_lsb = ^bus_addr[1:0];

    // Decode the access class from the byte offset.
    always_comb begin
        is_cfg = (bus_addr == CFG_A);
        is_buf = (bus_addr == BUF_A);
        is_dir = (word < NREG_W) && !is_cfg && !is_buf;
    end

    assign cfg_wr   = bus_sel && bus_wr && is_cfg;
    assign buf_acc  = bus_sel && is_buf;
    assign bank_we  = bus_sel && bus_wr && (is_buf || is_dir);
    assign bank_idx = is_buf ? win_idx : (is_dir ? IW'(word) : '1);

    tbw_cfg #(.DW(DW), .CNT_MAX(CNT_MAX)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(bus_wdata),
        .start_q(start_q), .cnt_q(cnt_q), .rd_word(cfg_word));

    tbw_seq #(.IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .new_start(bus_wdata[START_LSB +: FLD_W]),
        .start_q(start_q), .cnt_q(cnt_q), .buf_acc(buf_acc),
        .idx_q(win_idx), .done_q(burst_done));

    tbw_bank #(.DW(DW), .NREG(NREG), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .idx(bank_idx),
        .wdata(bus_wdata), .rdata(bank_rd));

    // Route the read data for the current access.
    always_comb begin
        if (is_cfg) bus_rdata = cfg_word;
        else        bus_rdata = bank_rd;
    end

    // R2
    cfg_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && is_cfg) |-> (bus_rdata[15:13] == 3'b0 && bus_rdata[7:5] == 3'b0))
        else $error("reserved config bits set");
endmodule

// File: tb/sim_tmr_burst_win.sv
module sim_tmr_burst_win;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        burst_done;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [18];
    int m_start = 0, m_cnt = 0, m_k = 0;

    always #4 clk = ~clk;  // 125 MHz

    tmr_burst_win u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .burst_done(burst_done));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle started at a negedge; returns read data and done after the edge.
    task automatic cyc(input bit wr, input logic [7:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output logic dn);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk); @(negedge clk);
        dn = burst_done;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wcfg(input int st, input int cn);
        logic [15:0] r; logic dn;
        cyc(1'b1, 8'h48, 16'(((cn & 31) << 8) | (st & 31)), r, dn);
        m_start = st; m_cnt = (cn > 17) ? 17 : cn; m_k = 0;
    endtask

    // Buffer access checked against the model; R4/R5/R6.
    task automatic bacc(input bit wr, input logic [15:0] d);
        logic [15:0] r; logic dn; int tgt; bit last;
        tgt = m_start + m_k; last = (m_k == m_cnt);
        cyc(wr, 8'h4C, d, r, dn);
        if (!wr) begin
            if (tgt < 18) chk(r == mem[tgt], "R4 window read", r, mem[tgt]);
            else          chk(r == 16'h0, "R6 out-of-range read", r, 0);
        end else if (tgt < 18) mem[tgt] = d;
        chk(dn == last, "R5 burst_done", dn, last);
        m_k = last ? 0 : m_k + 1;
    endtask

    task automatic verify_bank(input string req);
        logic [15:0] r; logic dn;
        for (int i = 0; i < 18; i++) begin
            cyc(1'b0, 8'(i * 4), 16'h0, r, dn);
            chk(r == mem[i], req, r, mem[i]);
        end
    endtask

    task automatic t_reset;
        logic [15:0] r; logic dn;
        chk(burst_done == 1'b0, "R1 done low", burst_done, 0);
        cyc(1'b0, 8'h48, 16'h0, r, dn);
        chk(r == 16'h0, "R1 config reset", r, 0);
        verify_bank("R1 bank reset");
    endtask

    task automatic t_fields;
        logic [15:0] r; logic dn;
        cyc(1'b1, 8'h48, 16'hFFE3, r, dn);   // count 31 -> 17, start 3
        m_start = 3; m_cnt = 17; m_k = 0;
        cyc(1'b0, 8'h48, 16'h0, r, dn);
        chk(r == 16'h1103, "R2 R3 config readback", r, 16'h1103);
        wcfg(9, 4);
        cyc(1'b0, 8'h48, 16'h0, r, dn);
        chk(r == 16'h0409, "R2 field placement", r, 16'h0409);
    endtask

    task automatic t_direct;
        logic [15:0] r; logic dn;
        for (int i = 0; i < 18; i++) begin
            cyc(1'b1, 8'(i * 4), 16'(16'hA500 + i), r, dn);
            mem[i] = 16'(16'hA500 + i);
        end
        verify_bank("R8 direct access");
    endtask

    task automatic t_burst(input int st, input int cn, input logic [15:0] seed);
        wcfg(st, cn);
        for (int k = 0; k <= m_cnt; k++) bacc(1'b1, 16'(seed + k * 3));
        for (int k = 0; k <= m_cnt; k++) bacc(1'b0, 16'h0);
        verify_bank("R4 bank after burst");
    endtask

    task automatic t_saturate;
        wcfg(0, 25);                         // 18-register run
        for (int k = 0; k < 18; k++) bacc(1'b1, 16'(16'h7000 + k));
        bacc(1'b0, 16'h0);                   // R3: rewound to index 0
        verify_bank("R3 saturated burst");
    endtask

    task automatic t_oob;
        logic [15:0] r; logic dn;
        wcfg(16, 3);
        for (int k = 0; k < 4; k++) bacc(1'b1, 16'(16'hBEE0 + k));
        for (int k = 0; k < 4; k++) bacc(1'b0, 16'h0);
        cyc(1'b0, 8'h48, 16'h0, r, dn);
        chk(r == 16'h0310, "R6 config untouched", r, 16'h0310);
        verify_bank("R6 bank untouched");
    endtask

    task automatic t_abort;
        wcfg(2, 5);
        bacc(1'b1, 16'h1111);
        bacc(1'b1, 16'h2222);
        wcfg(7, 1);                          // R7 abort
        bacc(1'b1, 16'h3333);
        bacc(1'b1, 16'h4444);
        bacc(1'b0, 16'h0);
        bacc(1'b0, 16'h0);
        verify_bank("R7 abort restart");
    endtask

    initial begin
        for (int i = 0; i < 18; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_direct();
        t_burst(0, 0, 16'h0100);
        t_burst(4, 6, 16'h2000);
        t_burst(11, 6, 16'h3300);
        t_saturate();
        t_oob();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule